// File: doc/BRIEF.md
# Parallel RGB Raster Timing Generator

The block produces the line and frame timing for a parallel RGB panel. A horizontal counter advances on every cycle in which the pixel-rate enable is high. A vertical counter advances once for each finished line. Both axes pass through the same five phases, always in this order: a one-cycle reference slot, the sync pulse, the back porch, the active region and the front porch. The outputs are the two sync levels, a data-enable, and the pixel coordinates inside the active area.

Software loads timing through a small write port. Each register word holds one quantity for both axes: the horizontal value sits in the low half and the vertical value in the high half. Writes go to a shadow set. The working set takes a copy of the shadow set when the generator is started and again at the end of every frame, so a frame in progress never changes shape. The reference slot is fixed at one cycle per axis, and software takes it out of the panel's front margin when it programs the front porch. The active size is limited to 1366 by 768.

Top module: `rgb_raster_gen`

## Requirements
- R1: After reset and until `start` is seen, `de` is 0, `pix_x` and `pix_y` are 0, and each sync output sits at its inactive level.
- R2: A line lasts 1 + S + B + A + F enabled cycles, where S, B, A and F are the horizontal sync, back porch, active and front porch values. The phases run in this order: reference (1), sync (S), back porch (B), active (A), front porch (F).
- R3: The vertical position moves only in the cycle after a line ends. A frame lasts 1 + S + B + A + F lines, using the vertical values.
- R4: Register addresses are 0 = sync width, 1 = back porch, 2 = front porch, 3 = active size. Bits 15:0 carry the horizontal value (the width for address 3) and bits 31:16 carry the vertical value (the height).
- R5: Writes go to a shadow set. The working set copies the shadow set only on a `start` that launches the generator, or in the last enabled cycle of the last line of a frame, so a write made mid-frame does not change the current frame.
- R6: `de` is 1 exactly when both axes are in their active region.
- R7: `pix_x` is the offset inside the horizontal active region and 0 outside it. `pix_y` is the same for the vertical axis.
- R8: `hsync` is 1 during the horizontal sync phase XOR `sync_inv[0]`. `vsync` is 1 during the vertical sync phase XOR `sync_inv[1]`.
- R9: A phase programmed to length 0 takes no cycle at all.
- R10: When the working set is loaded, an active width above 1366 becomes 1366 and an active height above 768 becomes 768.
- R11: While `pix_en` is 0, `de`, `pix_x` and `pix_y` hold their values.
- R12: A `start` while the generator is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate clock enable |
| start | input | 1 | Launches the generator from idle |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 2 | Shadow register address |
| wr_data | input | 32 | Write data: vertical value in 31:16, horizontal value in 15:0 |
| sync_inv | input | 2 | Polarity invert: bit 0 for horizontal sync, bit 1 for vertical sync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Horizontal active offset |
| pix_y | output | 16 | Vertical active offset |

## Verification
All outputs are decoded without further registers from the two position counters. An enabled edge, a `start` or a working-set load therefore shows up at the outputs right after that clock edge, and a change of `sync_inv` shows up within the same cycle. A bench model updates its own positions, shadow set and working set at every rising edge, using the same rules as the requirements. The outputs are compared against that model at the following falling edge, which is one full register stage after the stimulus and well away from the edge. Shadow writes are checked one frame later, when the model predicts the copy.

// File: rtl/rgb_raster_pkg.sv
package rgb_raster_pkg;

  localparam int CFG_W = 16;
  localparam int AXES  = 2;
  localparam int NREG  = 4;

  localparam logic [1:0] ADDR_SYNC  = 2'd0;
  localparam logic [1:0] ADDR_BACK  = 2'd1;
  localparam logic [1:0] ADDR_FRONT = 2'd2;
  localparam logic [1:0] ADDR_ACT   = 2'd3;

  typedef enum logic [2:0] {
    PH_REF   = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  typedef struct packed {
    logic [CFG_W-1:0] sync;
    logic [CFG_W-1:0] back;
    logic [CFG_W-1:0] front;
    logic [CFG_W-1:0] act;
  } axis_cfg_t;

endpackage

// File: rtl/rgb_raster_regs.sv
module rgb_raster_regs
  import rgb_raster_pkg::*;
#(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        load,
  output axis_cfg_t   work [AXES]
);

  logic [31:0] shadow_q [NREG];
  logic [31:0] shadow_d [NREG];

  // Shadow set: software-visible copy, written at any time
  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) shadow_d[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
    end else begin
      shadow_q <= shadow_d;
    end
  end

  // Working set per axis, refreshed only on load, active size clamped
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    localparam logic [CFG_W-1:0] LIMIT = (a == 0) ? CFG_W'(MAX_W) : CFG_W'(MAX_H);
    localparam int LO = a * CFG_W;

    axis_cfg_t        work_q, work_d, fresh;
    logic [CFG_W-1:0] act_raw;

    assign act_raw = shadow_q[ADDR_ACT][LO +: CFG_W];

    always_comb begin
      fresh.sync  = shadow_q[ADDR_SYNC][LO +: CFG_W];
      fresh.back  = shadow_q[ADDR_BACK][LO +: CFG_W];
      fresh.front = shadow_q[ADDR_FRONT][LO +: CFG_W];
      fresh.act   = (act_raw > LIMIT) ? LIMIT : act_raw;
      work_d      = load ? fresh : work_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) work_q <= '0;
      else        work_q <= work_d;
    end

    assign work[a] = work_q;
  end

endmodule

// File: rtl/rgb_raster_axis.sv
module rgb_raster_axis
  import rgb_raster_pkg::*;
#(
  parameter int CW = CFG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output logic             wrap,
  output phase_e           phase,
  output logic [CFG_W-1:0] coord
);

  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] end_ref, end_sync, end_back, end_act, last;

  // Phase boundaries: a zero-length phase yields equal boundaries and is skipped
  assign end_ref  = CW'(1);
  assign end_sync = end_ref  + CW'(cfg.sync);
  assign end_back = end_sync + CW'(cfg.back);
  assign end_act  = end_back + CW'(cfg.act);
  assign last     = end_act  + CW'(cfg.front) - CW'(1);

  always_comb begin
    if (pos_q < end_ref)       phase = PH_REF;
    else if (pos_q < end_sync) phase = PH_SYNC;
    else if (pos_q < end_back) phase = PH_BACK;
    else if (pos_q < end_act)  phase = PH_ACT;
    else                       phase = PH_FRONT;
  end

  assign coord = (phase == PH_ACT) ? CFG_W'(pos_q - end_back) : '0;
  assign wrap  = step && (pos_q == last);

  always_comb begin
    pos_d = pos_q;
    if (clr)       pos_d = '0;
    else if (wrap) pos_d = '0;
    else if (step) pos_d = pos_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

endmodule

// File: rtl/rgb_raster_gen.sv
module rgb_raster_gen
  import rgb_raster_pkg::*;
#(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             start,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       sync_inv,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CFG_W-1:0] pix_x,
  output logic [CFG_W-1:0] pix_y
);

  localparam int CW = CFG_W + 2;

  logic             running_q, running_d;
  logic             go, load;
  logic [AXES-1:0]  step, wrap, in_act, sync_lvl;
  phase_e           phase [AXES];
  logic [CFG_W-1:0] coord [AXES];
  axis_cfg_t        work  [AXES];

  assign go   = start && !running_q;
  assign load = go || wrap[AXES-1];

  always_comb begin
    running_d = running_q;
    if (go) running_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running_q <= 1'b0;
    else        running_q <= running_d;
  end

  rgb_raster_regs #(
    .MAX_W(MAX_W),
    .MAX_H(MAX_H)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (load),
    .work    (work)
  );

  // Axis 0 counts enabled pixels; each further axis counts wraps of the one below
  for (genvar a = 0; a < AXES; a++) begin : g_ax
    if (a == 0) begin : g_base
      assign step[a] = running_q && pix_en;
    end else begin : g_chain
      assign step[a] = wrap[a-1];
    end

    rgb_raster_axis #(
      .CW(CW)
    ) u_axis (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (go),
      .step  (step[a]),
      .cfg   (work[a]),
      .wrap  (wrap[a]),
      .phase (phase[a]),
      .coord (coord[a])
    );

    assign in_act[a]   = (phase[a] == PH_ACT);
    assign sync_lvl[a] = (phase[a] == PH_SYNC) ^ sync_inv[a];
  end

  assign hsync = sync_lvl[0];
  assign vsync = sync_lvl[1];
  assign de    = &in_act;
  assign pix_x = coord[0];
  assign pix_y = coord[1];

endmodule

// File: rtl/rgb_raster_chk.sv
module rgb_raster_chk
  import rgb_raster_pkg::*;
#(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             running,
  input logic             load,
  input logic             h_wrap,
  input axis_cfg_t        h_cfg,
  input axis_cfg_t        v_cfg,
  input logic             de,
  input logic [CFG_W-1:0] pix_x,
  input logic [CFG_W-1:0] pix_y
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!de && pix_x == '0 && pix_y == '0));

  assert_row_after_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_y) |-> $past(h_wrap));

  assert_copy_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(h_cfg) || !$stable(v_cfg)) |-> $past(load));

  assert_de_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x < h_cfg.act && pix_y < v_cfg.act));

  assert_size_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cfg.act <= CFG_W'(MAX_W)) && (v_cfg.act <= CFG_W'(MAX_H)));

  assert_hold_when_idle_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pix_en) |=> ($stable(de) && $stable(pix_x) && $stable(pix_y)));

  assert_stays_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

endmodule

bind rgb_raster_gen rgb_raster_chk #(
  .MAX_W(MAX_W),
  .MAX_H(MAX_H)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pix_en  (pix_en),
  .running (running_q),
  .load    (load),
  .h_wrap  (wrap[0]),
  .h_cfg   (work[0]),
  .v_cfg   (work[1]),
  .de      (de),
  .pix_x   (pix_x),
  .pix_y   (pix_y)
);

// File: tb/rgb_raster_gen_tb.sv
`timescale 1ns/1ps
module rgb_raster_gen_tb;

  localparam int LIM_W = 1366;
  localparam int LIM_H = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        start = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  sync_inv = '0;
  logic        hsync, vsync, de;
  logic [15:0] pix_x, pix_y;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string sc = "R1";
  int    max_x = 0;

  always #4 clk = ~clk;

  rgb_raster_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .start(start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sync_inv(sync_inv),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  // Reference model: index 0 sync, 1 back, 2 front, 3 active (R4 address map)
  bit          m_run;
  int          m_h, m_v;
  logic [31:0] m_sh [4];
  int          mh [4];
  int          mv [4];

  function automatic int phase_of(int pos, int s, int b, int a);
    if (pos < 1)             return 0;
    if (pos < 1 + s)         return 1;
    if (pos < 1 + s + b)     return 2;
    if (pos < 1 + s + b + a) return 3;
    return 4;
  endfunction

  function automatic int last_of(int s, int b, int a, int f);
    return s + b + a + f;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit go, hstep, hwrap, fend;
    int hl, vl, ha, va;
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0;
      for (int i = 0; i < 4; i++) begin m_sh[i] = '0; mh[i] = 0; mv[i] = 0; end
    end else begin
      go    = start && !m_run;
      hstep = m_run && pix_en;
      hl    = last_of(mh[0], mh[1], mh[3], mh[2]);
      vl    = last_of(mv[0], mv[1], mv[3], mv[2]);
      hwrap = hstep && (m_h == hl);
      fend  = hwrap && (m_v == vl);
      if (go) begin
        m_run = 1; m_h = 0; m_v = 0;
      end else if (hstep) begin
        if (hwrap) begin
          m_h = 0;
          m_v = (m_v == vl) ? 0 : m_v + 1;
        end else begin
          m_h = m_h + 1;
        end
      end
      if (go || fend) begin
        for (int i = 0; i < 4; i++) begin
          mh[i] = int'(m_sh[i][15:0]);
          mv[i] = int'(m_sh[i][31:16]);
        end
        ha = mh[3]; va = mv[3];
        mh[3] = (ha > LIM_W) ? LIM_W : ha;
        mv[3] = (va > LIM_H) ? LIM_H : va;
      end
      if (wr_en) m_sh[wr_addr] = wr_data;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s [%s]: got %0d expected %0d", req, what, sc, act, exp);
    end
  endtask

  task automatic compare();
    int hp, vp, ex, ey;
    hp = phase_of(m_h, mh[0], mh[1], mh[3]);
    vp = phase_of(m_v, mv[0], mv[1], mv[3]);
    ex = (hp == 3) ? m_h - (1 + mh[0] + mh[1]) : 0;
    ey = (vp == 3) ? m_v - (1 + mv[0] + mv[1]) : 0;
    chk(hsync === ((hp == 1) ^ sync_inv[0]), "R2/R8", "hsync", int'(hsync), int'((hp == 1) ^ sync_inv[0]));
    chk(vsync === ((vp == 1) ^ sync_inv[1]), "R3/R8", "vsync", int'(vsync), int'((vp == 1) ^ sync_inv[1]));
    chk(de === (hp == 3 && vp == 3), "R6", "de", int'(de), int'(hp == 3 && vp == 3));
    chk(int'(pix_x) == ex, "R7", "pix_x", int'(pix_x), ex);
    chk(int'(pix_y) == ey, "R7", "pix_y", int'(pix_y), ey);
    if (int'(pix_x) > max_x) max_x = int'(pix_x);
  endtask

  task automatic run(int n, int pct, int wr_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      start  = 1'b0;
      wr_en  = 1'b0;
      pix_en = ($urandom % 100) < pct;
      if (($urandom % 1000) < wr_pct) begin
        wr_en   = 1'b1;
        wr_addr = 2'($urandom % 4);
        wr_data = {16'($urandom % 7), 16'($urandom % 7)};
        if (wr_addr == 2'd3) wr_data = wr_data + 32'h0001_0001;
      end
      if (wr_pct > 0 && ($urandom % 100) == 0) sync_inv = 2'($urandom % 4);
    end
  endtask

  task automatic wr(int a, int v, int h);
    @(negedge clk);
    compare();
    start   = 1'b0;
    wr_en   = 1'b1;
    wr_addr = 2'(a);
    wr_data = {16'(v), 16'(h)};
  endtask

  task automatic kick();
    @(negedge clk);
    compare();
    wr_en = 1'b0;
    start = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; pix_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(de === 1'b0 && pix_x == 16'd0 && pix_y == 16'd0, "R1", "idle in reset", int'(de), 0);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed_v;
    seed_v = $urandom(32'd7731);
    sync_inv = 2'b00;
    do_reset();
    sc = "R1";
    run(12, 100, 0);
    chk(de === 1'b0 && hsync === 1'b0 && vsync === 1'b0, "R1", "idle before start", int'(de), 0);

    sc = "R4";
    wr(0, 1, 2);
    wr(1, 1, 3);
    wr(2, 1, 2);
    wr(3, 3, 5);
    kick();
    run(200, 100, 0);

    sc = "R12";
    kick();
    run(60, 100, 0);

    sc = "R5";
    wr(1, 2, 0);
    wr(2, 0, 2);
    wr(0, 0, 1);
    sc = "R9";
    run(400, 100, 0);

    sc = "R8";
    sync_inv = 2'b11;
    run(150, 100, 0);
    sync_inv = 2'b01;

    sc = "R11";
    run(2000, 40, 0);

    sc = "R2 random";
    run(20000, 70, 20);

    sync_inv = 2'b00;
    do_reset();
    sc = "R10";
    wr(0, 0, 1);
    wr(1, 0, 1);
    wr(2, 0, 1);
    wr(3, 1000, 2000);
    kick();
    max_x = 0;
    run(3000, 100, 0);
    chk(max_x == LIM_W - 1, "R10", "largest pix_x", max_x, LIM_W - 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule